// File: doc/BRIEF.md
# Homogeneous Pushdown Automaton Bank

This block runs one deterministic homogeneous pushdown automaton with up to `NS` states (256 by default). Each state stores one input symbol it accepts, one stack symbol it requires (or a wildcard), a stack action made of a push symbol and a pop count, an epsilon bit and a report bit. A bit matrix of state-to-state edges decides which states are enabled after a state fires. Every cycle the bank looks up two match vectors. One comes from the 8-bit input symbol and the other from the 8-bit top-of-stack symbol supplied by a separate stack unit. It ANDs both with the enabled-state vector, picks the firing state and presents that state's stack action in the same cycle, so the stack unit can update on the same clock edge.

Input symbols arrive on a valid/ready stream. A symbol is consumed only on a cycle where `in_valid` and `in_ready` are both high. The bank drops `in_ready` in two cases: while an epsilon step is pending, and after a rejection. The source must then hold its symbol steady. When the set of enabled successors contains an epsilon state, the next cycle is an epsilon step. That step consumes no input, and only stack match and enable gate it. If a step finds no matching state, the automaton rejects and freezes until reset. Configuration is written through a plain port while the stream is idle. Reset clears all configuration and enables only the start state.

Top module: `pda_bank`

## Requirements
- R1: After reset only state `START` (0) is enabled. `in_ready` is 1, and `eps_stall`, `reject`, `act_valid` and `report` are 0. All state attributes and edges are cleared, so an unconfigured state never matches.
- R2: On a step, a state fires only if three conditions hold: it is enabled, its input label equals `in_sym`, and its stack label equals `tos`. A step is either an accepted symbol (`in_valid && in_ready`) or an epsilon step. `act_valid` is high in exactly the cycle of a firing step.
- R3: A state configured with the stack wildcard (`cfg_stk_any`=1) matches any `tos` value.
- R4: During a firing step, `act` equals the fired state's action: push symbol in bits 15:8 (0 means no push) and pop count in bits 7:0. A pop count above 1 is a multipop. `act` is 0 when `act_valid` is low.
- R5: `fire_state` gives the fired state's index during a firing step and is 0 otherwise. After a firing step, the enabled set is exactly the row of the edge matrix for the fired state. Edge (i,j) is written with `cfg_edge`=1, `cfg_src`=i, `cfg_dst`=j and data `cfg_edge_on`.
- R6: If the new enabled set contains an epsilon state, `eps_stall` is 1 and `in_ready` is 0 in the next cycle, and the presented symbol is not consumed. In that cycle a step occurs regardless of `in_valid`, and only enabled epsilon states with a stack match can fire.
- R7: A step with no firing state sets `reject`. `reject` stays 1 until reset, and while it is set `in_ready`, `act_valid` and `report` are 0.
- R8: `report` is 1 exactly in a firing step whose fired state has its report bit set.
- R9: If several states would fire at once, the lowest index wins.
- R10: While `in_valid` is 0 and no epsilon step is pending, nothing fires and the enabled set is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_edge | input | 1 | 1: write an edge bit, 0: write state attributes |
| cfg_src | input | 8 | State written, or edge source |
| cfg_dst | input | 8 | Edge destination |
| cfg_edge_on | input | 1 | Edge bit value |
| cfg_in_sym | input | 8 | Input label of the state |
| cfg_stk_sym | input | 8 | Stack label of the state |
| cfg_stk_any | input | 1 | Stack wildcard |
| cfg_push | input | 8 | Push symbol (0 = none) |
| cfg_pop | input | 8 | Pop count |
| cfg_eps | input | 1 | State is an epsilon state |
| cfg_report | input | 1 | State reports when it fires |
| in_valid | input | 1 | Input symbol valid |
| in_sym | input | 8 | Input symbol |
| in_ready | output | 1 | Bank accepts the symbol |
| tos | input | 8 | Top-of-stack symbol from the stack unit |
| act_valid | output | 1 | A state fired this cycle |
| act | output | 16 | Stack action {push, pop} |
| fire_state | output | 8 | Index of the fired state |
| eps_stall | output | 1 | Epsilon step in progress, input held |
| report | output | 1 | Fired state is a reporting state |
| reject | output | 1 | Sticky rejection flag |

## Verification
Two functions can coincide in one cycle: an epsilon step and a presented symbol. The bench keeps `in_valid` high with the next symbol while the epsilon step runs. It then expects the epsilon state to fire with `in_ready` low, and the held symbol to be consumed only in the following cycle. Priority selection and a report also coincide when two enabled wildcard states both match one symbol. A behavioural model predicts every output on every cycle, so a wrong winner or a consumed symbol shows up as a miscompare.

// File: rtl/pda_pkg.sv
package pda_pkg;
  localparam int SYM_W = 8;

  typedef struct packed {
    logic [SYM_W-1:0] push;
    logic [SYM_W-1:0] pop;
  } stk_act_t;
endpackage

// File: rtl/pda_label_tables.sv
// Input-label and stack-label tables: one row per symbol, one column per state.
module pda_label_tables #(
  parameter int NS = 256,
  parameter int SW = 8,
  localparam int NSYM = 1 << SW,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_state,
  input  logic [SW-1:0] wr_in_sym,
  input  logic [SW-1:0] wr_stk_sym,
  input  logic          wr_stk_any,
  input  logic [SW-1:0] rd_in_sym,
  input  logic [SW-1:0] rd_tos,
  output logic [NS-1:0] im_row,
  output logic [NS-1:0] sm_row
);
  logic [NS-1:0] in_tab  [NSYM];
  logic [NS-1:0] stk_tab [NSYM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NSYM; r++) begin
        in_tab[r]  <= '0;
        stk_tab[r] <= '0;
      end
    end else if (wr_en) begin
      for (int r = 0; r < NSYM; r++) begin
        in_tab[r][wr_state]  <= (SW'(r) == wr_in_sym);
        stk_tab[r][wr_state] <= wr_stk_any || (SW'(r) == wr_stk_sym);
      end
    end
  end

  assign im_row = in_tab[rd_in_sym];
  assign sm_row = stk_tab[rd_tos];
endmodule

// File: rtl/pda_state_attrs.sv
// Per-state action, epsilon and report attributes.
module pda_state_attrs
  import pda_pkg::*;
#(
  parameter int NS = 256,
  localparam int IW = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_state,
  input  logic [SYM_W-1:0] wr_push,
  input  logic [SYM_W-1:0] wr_pop,
  input  logic             wr_eps,
  input  logic             wr_report,
  input  logic [IW-1:0]    rd_state,
  output stk_act_t         rd_act,
  output logic             rd_report,
  output logic [NS-1:0]    eps_mask
);
  stk_act_t      act_tab [NS];
  logic [NS-1:0] rep_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) act_tab[s] <= '0;
      eps_mask <= '0;
      rep_mask <= '0;
    end else if (wr_en) begin
      act_tab[wr_state]  <= '{push: wr_push, pop: wr_pop};
      eps_mask[wr_state] <= wr_eps;
      rep_mask[wr_state] <= wr_report;
    end
  end

  assign rd_act    = act_tab[rd_state];
  assign rd_report = rep_mask[rd_state];
endmodule

// File: rtl/pda_route.sv
// Edge matrix: row i holds the successors of state i.
module pda_route #(
  parameter int NS = 256,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_src,
  input  logic [IW-1:0] wr_dst,
  input  logic          wr_bit,
  input  logic [IW-1:0] rd_src,
  output logic [NS-1:0] succ_row
);
  logic [NS-1:0] edge_tab [NS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) edge_tab[s] <= '0;
    end else if (wr_en) begin
      edge_tab[wr_src][wr_dst] <= wr_bit;
    end
  end

  assign succ_row = edge_tab[rd_src];
endmodule

// File: rtl/pda_first_set.sv
// Lowest-index set bit of a vector.
module pda_first_set #(
  parameter int W = 256,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          hit
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    hit = |vec;
  end
endmodule

// File: rtl/pda_bank.sv
module pda_bank
  import pda_pkg::*;
#(
  parameter int NS = 256,
  parameter int START = 0,
  localparam int IW = $clog2(NS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_edge,
  input  logic [IW-1:0]      cfg_src,
  input  logic [IW-1:0]      cfg_dst,
  input  logic               cfg_edge_on,
  input  logic [SYM_W-1:0]   cfg_in_sym,
  input  logic [SYM_W-1:0]   cfg_stk_sym,
  input  logic               cfg_stk_any,
  input  logic [SYM_W-1:0]   cfg_push,
  input  logic [SYM_W-1:0]   cfg_pop,
  input  logic               cfg_eps,
  input  logic               cfg_report,
  input  logic               in_valid,
  input  logic [SYM_W-1:0]   in_sym,
  output logic               in_ready,
  input  logic [SYM_W-1:0]   tos,
  output logic               act_valid,
  output logic [2*SYM_W-1:0] act,
  output logic [IW-1:0]      fire_state,
  output logic               eps_stall,
  output logic               report,
  output logic               reject
);
  logic [NS-1:0] en_q, im_row, sm_row, im_eff, fire_vec, succ_row, eps_mask;
  logic          eps_q, err_q, hit, step, fire_rep;
  logic [IW-1:0] f_idx;
  stk_act_t      f_act;
  logic          attr_we, edge_we;

  assign attr_we = cfg_we && !cfg_edge;
  assign edge_we = cfg_we && cfg_edge;

  pda_label_tables #(.NS(NS), .SW(SYM_W)) u_labels (
    .clk(clk), .rst_n(rst_n), .wr_en(attr_we), .wr_state(cfg_src),
    .wr_in_sym(cfg_in_sym), .wr_stk_sym(cfg_stk_sym), .wr_stk_any(cfg_stk_any),
    .rd_in_sym(in_sym), .rd_tos(tos), .im_row(im_row), .sm_row(sm_row)
  );

  pda_state_attrs #(.NS(NS)) u_attrs (
    .clk(clk), .rst_n(rst_n), .wr_en(attr_we), .wr_state(cfg_src),
    .wr_push(cfg_push), .wr_pop(cfg_pop), .wr_eps(cfg_eps),
    .wr_report(cfg_report), .rd_state(f_idx), .rd_act(f_act),
    .rd_report(fire_rep), .eps_mask(eps_mask)
  );

  pda_route #(.NS(NS)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_en(edge_we), .wr_src(cfg_src),
    .wr_dst(cfg_dst), .wr_bit(cfg_edge_on), .rd_src(f_idx),
    .succ_row(succ_row)
  );

  // During an epsilon step only epsilon states see an input match.
  assign im_eff   = eps_q ? eps_mask : im_row;
  assign fire_vec = en_q & im_eff & sm_row;

  pda_first_set #(.W(NS)) u_pick (.vec(fire_vec), .idx(f_idx), .hit(hit));

  assign step       = !err_q && (eps_q || in_valid);
  assign in_ready   = !eps_q && !err_q;
  assign act_valid  = step && hit;
  assign act        = act_valid ? f_act : '0;
  assign fire_state = act_valid ? f_idx : '0;
  assign report     = act_valid && fire_rep;
  assign eps_stall  = eps_q;
  assign reject     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= NS'(1) << START;
      eps_q <= 1'b0;
      err_q <= 1'b0;
    end else if (step) begin
      if (hit) begin
        en_q  <= succ_row;
        eps_q <= |(succ_row & eps_mask);
      end else begin
        err_q <= 1'b1;
        eps_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pda_bank_chk.sv
module pda_bank_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic act_valid,
  input logic eps_stall,
  input logic report,
  input logic reject
);
  // R7
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> reject);
  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!act_valid && !in_ready));
  // R6
  eps_holds_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eps_stall |-> !in_ready);
  // R10
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !eps_stall) |-> !act_valid);
  // R8
  report_with_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    report |-> act_valid);
  // R2
  fire_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> ((in_valid && in_ready) || eps_stall));
endmodule

bind pda_bank pda_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .act_valid(act_valid), .eps_stall(eps_stall), .report(report),
  .reject(reject)
);

// File: tb/pda_bank_bench.sv
`timescale 1ns/1ps
module pda_bank_bench;
  localparam int NS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_edge = 0, cfg_edge_on = 0, cfg_stk_any = 0;
  logic cfg_eps = 0, cfg_report = 0, in_valid = 0;
  logic [7:0] cfg_src = 0, cfg_dst = 0, cfg_in_sym = 0, cfg_stk_sym = 0;
  logic [7:0] cfg_push = 0, cfg_pop = 0, in_sym = 0, tos = 0;
  logic in_ready, act_valid, eps_stall, report, reject;
  logic [15:0] act;
  logic [7:0] fire_state;

  always #2.5 clk = ~clk;

  pda_bank u_pda_bank (.*);

  // Behavioural reference model
  int  m_in[NS], m_stk[NS], m_push[NS], m_pop[NS];
  bit  m_any[NS], m_eps[NS], m_rep[NS];
  bit  m_edge[NS][NS];
  bit  m_en[NS];
  bit  m_epsq, m_err;
  int  n_chk = 0, n_fail = 0;
  bit  last_took;
  string spot_req = "";
  int  spot_state = 0;

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      m_in[s] = -1; m_stk[s] = -1; m_push[s] = 0; m_pop[s] = 0;
      m_any[s] = 0; m_eps[s] = 0; m_rep[s] = 0; m_en[s] = (s == 0);
      for (int d = 0; d < NS; d++) m_edge[s][d] = 0;
    end
    m_epsq = 0; m_err = 0;
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  // Compare at mid-cycle, then advance the model on the rising edge.
  task automatic cycle();
    bit step; int f; bit rdy;
    #1;
    step = !m_err && (m_epsq || in_valid);
    rdy  = !m_epsq && !m_err;
    f = -1;
    for (int s = NS - 1; s >= 0; s--)
      if (m_en[s] && (m_epsq ? m_eps[s] : (m_in[s] == int'(in_sym)))
          && (m_any[s] || m_stk[s] == int'(tos))) f = s;
    chk("R10 in_ready", int'(in_ready), int'(rdy));
    chk("R6 eps_stall", int'(eps_stall), int'(m_epsq));
    chk("R7 reject", int'(reject), int'(m_err));
    chk("R2 act_valid", int'(act_valid), int'(step && f >= 0));
    chk("R4 act", int'(act), (step && f >= 0) ? (m_push[f] * 256 + m_pop[f]) : 0);
    chk("R5 fire_state", int'(fire_state), (step && f >= 0) ? f : 0);
    chk("R8 report", int'(report), (step && f >= 0) ? int'(m_rep[f]) : 0);
    if (spot_req != "") chk(spot_req, int'(fire_state), spot_state);
    last_took = in_valid && rdy;
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (cfg_we) begin
        if (cfg_edge) m_edge[cfg_src][cfg_dst] = cfg_edge_on;
        else begin
          m_in[cfg_src] = cfg_in_sym; m_stk[cfg_src] = cfg_stk_sym;
          m_any[cfg_src] = cfg_stk_any; m_push[cfg_src] = cfg_push;
          m_pop[cfg_src] = cfg_pop; m_eps[cfg_src] = cfg_eps;
          m_rep[cfg_src] = cfg_report;
        end
      end
      if (step) begin
        if (f >= 0) begin
          m_epsq = 0;
          for (int d = 0; d < NS; d++) begin
            m_en[d] = m_edge[f][d];
            if (m_edge[f][d] && m_eps[d]) m_epsq = 1;
          end
        end else begin
          m_err = 1; m_epsq = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic set_state(int s, int isym, int ssym, bit any, int push,
                           int pop, bit eps, bit rep);
    cfg_we = 1; cfg_edge = 0; cfg_src = 8'(s); cfg_in_sym = 8'(isym);
    cfg_stk_sym = 8'(ssym); cfg_stk_any = any; cfg_push = 8'(push);
    cfg_pop = 8'(pop); cfg_eps = eps; cfg_report = rep;
    cycle();
    cfg_we = 0;
  endtask

  task automatic set_edge(int s, int d);
    cfg_we = 1; cfg_edge = 1; cfg_src = 8'(s); cfg_dst = 8'(d); cfg_edge_on = 1;
    cycle();
    cfg_we = 0; cfg_edge = 0;
  endtask

  // Present a symbol until accepted (bounded: a rejected bank never accepts).
  task automatic feed(int sym, int t);
    in_valid = 1; in_sym = 8'(sym); tos = 8'(t);
    for (int k = 0; k < 4; k++) begin
      cycle();
      if (last_took) break;
    end
    in_valid = 0; spot_req = "";
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    cycle(); cycle();
    rst_n = 1;
    // R1: reset state over a few idle cycles; R10: idle keeps state
    repeat (3) cycle();

    // Program: 0 -a,*-> push 11 ; 1 -b,11-> pop1 report ; 2 -b,22-> ;
    // 3 eps,* pop2 push 33 (multipop) ; 4 -c,*-> report ; 5 -a,*->
    set_state(0, 8'h61, 0,     1, 8'h11, 0, 0, 0);
    set_state(1, 8'h62, 8'h11, 0, 0,     1, 0, 1);
    set_state(2, 8'h62, 8'h22, 0, 8'h44, 0, 0, 0);
    set_state(3, 8'h7a, 0,     1, 8'h33, 2, 1, 0);
    set_state(4, 8'h63, 0,     1, 0,     0, 0, 1);
    set_state(5, 8'h61, 0,     1, 8'h55, 1, 0, 1);
    set_edge(0, 1); set_edge(0, 2); set_edge(1, 3);
    set_edge(3, 4); set_edge(4, 0); set_edge(4, 5);
    repeat (2) cycle();  // R10

    spot_req = "R3 wildcard fire"; spot_state = 0;
    feed(8'h61, 8'h05);
    feed(8'h62, 8'h11);  // R2: state 2 stack mismatch, state 1 fires, R8 report
    // R6: symbol held while the epsilon state fires
    in_valid = 1; in_sym = 8'h63; tos = 8'h9a;
    spot_req = "R6 eps fire"; spot_state = 3;
    cycle();
    spot_req = "";
    feed(8'h63, 8'h40);  // consumed after the stall, state 4 reports
    spot_req = "R9 lowest wins"; spot_state = 0;
    feed(8'h61, 8'h00);
    feed(8'h62, 8'h22);  // state 2 fires, no successors
    feed(8'h78, 8'h00);  // R7 reject
    in_valid = 1; in_sym = 8'h61;
    repeat (3) cycle();  // R7 sticky, input never taken
    in_valid = 0;

    // R1: reset clears configuration
    rst_n = 0; cycle(); rst_n = 1;
    repeat (2) cycle();
    feed(8'h61, 8'h00);  // unconfigured start state rejects (R1, R7)
    repeat (2) cycle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule